// File: doc/BRIEF.md
# Infrared Run-Length Sample Receiver

This block turns a demodulated infrared input line into a stream of run-length bytes. The line passes through a two-flop synchroniser and is sampled once per sample period. The period is chosen from four settings. Each stretch of constant level becomes one byte: bit 7 is the level (1 = pulse, 0 = space) and bits 6:0 give the number of sample periods the stretch lasted. A stretch longer than the count field can hold is split into saturated bytes followed by a remainder byte. A packet opens at the first pulse sample. It closes when the trailing space has lasted the programmed idle limit; at that point a dedicated end marker is written.

The bytes go into a receive FIFO, which software drains through a show-ahead read port. Four sticky status flags report the receive side: data ready, trigger level reached, packet end and overrun. They are cleared by writing ones, and the flags that are enabled combine into one interrupt line. When the device is disabled, the FIFO count reads as all ones.

Top module: `irrl_rx_top`

## Requirements
- R1: Each run of constant sampled level is pushed as one byte when the level changes. The byte is {level, length}: bit 7 = 1 for a pulse and 0 for a space, bits 6:0 = the run length in sample periods (1..127). Bytes keep the order of the runs.
- R2: For a run of k > 127 periods, the block first pushes (k-1)/127 saturated bytes with bits 6:0 = 0x7F (0xFF for a pulse, 0x7F for a space), then the remainder byte of length k - 127*((k-1)/127).
- R3: While no packet is open, space samples are ignored and the first pulse sample opens a packet. Driving rx_en low stops sampling and drops the open run without pushing anything.
- R4: With L = {limit_hi, limit_lo} >= 2, when a space run reaches L periods the block drops the space remainder, pushes 0x80, sets status bit 5 (packet end) and returns to idle. L = 0 or 1 disables packet end.
- R5: The sample period is CLK_PER_US clock cycles times 50, 1, 25 or 100 microseconds, for period_sel 00, 01, 10 and 11 respectively.
- R6: With rx_invert high, a low line is treated as a pulse and a high line as a space.
- R7: status bit positions are 7 data ready, 6 trigger reached, 5 packet end and 4 overrun; bits 3:0 read 0. A one in status_clr clears the matching bit on the next edge. A set event in the same cycle wins over the clear.
- R8: Data ready (bit 7) is set on every accepted push. Trigger reached (bit 6) is set while the FIFO count is at least trig_lvl and trig_lvl is not 0.
- R9: A push into a full FIFO is dropped, leaves the stored bytes and their order unchanged, and sets both overrun (bit 4) and data ready (bit 7).
- R10: A pulse on fifo_clr empties the FIFO, so the count is 0 on the next cycle.
- R11: fifo_cnt shows the number of stored bytes while dev_en is high and reads 0xFF while dev_en is low.
- R12: irq is high exactly when some status bit and its matching irq_en bit are both high.
- R13: rd_data always shows the oldest stored byte, and rd_en removes it on the next edge. rd_en on an empty FIFO is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated IR line (asynchronous) |
| dev_en | input | 1 | Device enable; when low, the FIFO count reads 0xFF |
| rx_en | input | 1 | Receive enable; gates sampling |
| rx_invert | input | 1 | Treat a low line as a pulse |
| period_sel | input | 2 | Sample period select |
| limit_hi | input | 8 | Idle limit, upper byte |
| limit_lo | input | 8 | Idle limit, lower byte |
| trig_lvl | input | 8 | FIFO trigger level; 0 disables |
| fifo_clr | input | 1 | Empty the FIFO |
| rd_en | input | 1 | Remove the oldest byte |
| rd_data | output | 8 | Oldest stored byte |
| fifo_cnt | output | 8 | Stored byte count, or 0xFF when disabled |
| status_clr | input | 8 | Write-one-to-clear mask for status |
| irq_en | input | 8 | Interrupt enable per status bit |
| status | output | 8 | Sticky status flags |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the per-cycle rules on every cycle. Every pushed run byte has a non-zero length. The packer is idle after an end marker. A packet end and an overrun leave their flags set on the next cycle. A write-one clear takes effect. A FIFO clear leaves the FIFO empty. A full FIFO never changes its count on a dropped push. Only the bench's scenarios can show that whole byte streams are correct: saturation splitting, inversion, the four sample periods, the idle limit and its disabled setting, and overrun keeping the oldest bytes in order. The bench checks these by draining the FIFO against bytes computed from the driven run lengths.

// File: rtl/irrl_pkg.sv
package irrl_pkg;
  localparam int STS_W   = 8;
  localparam int BIT_RDR = 7;
  localparam int BIT_RTR = 6;
  localparam int BIT_PE  = 5;
  localparam int BIT_RFO = 4;
  localparam logic [7:0] END_MARK = 8'h80;
  localparam logic [6:0] RUN_MAX  = 7'h7F;

  // Sample period in microseconds for each select code.
  function automatic int unsigned period_us(input logic [1:0] sel);
    case (sel)
      2'b01:   return 1;
      2'b10:   return 25;
      2'b11:   return 100;
      default: return 50;
    endcase
  endfunction

  // Build one run-length byte from a level and a length.
  function automatic logic [7:0] run_byte(input logic lvl, input logic [6:0] len);
    return {lvl, len};
  endfunction
endpackage

// File: rtl/irrl_sampler.sv
module irrl_sampler
  import irrl_pkg::*;
#(
  parameter int CLK_PER_US = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       invert,
  input  logic [1:0] per_sel,
  input  logic       ir_in,
  output logic       level,
  output logic       tick
);
  localparam int CNT_W = $clog2(CLK_PER_US * 100 + 1);

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] div_q;
  logic [CNT_W-1:0] div_lim;

  always_comb div_lim = CNT_W'(CLK_PER_US * period_us(per_sel) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      div_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], ir_in};
      if (!rx_en || div_q >= div_lim) div_q <= '0;
      else                            div_q <= div_q + 1'b1;
    end
  end

  assign tick  = rx_en && (div_q >= div_lim);
  assign level = sync_q[1] ^ invert;
endmodule

// File: rtl/irrl_packer.sv
module irrl_packer
  import irrl_pkg::*;
#(
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             tick,
  input  logic             level,
  input  logic [LIM_W-1:0] limit,
  output logic             push,
  output logic [7:0]       push_byte,
  output logic             end_evt
);
  logic             act_q, act_d;
  logic             lvl_q, lvl_d;
  logic [6:0]       run_q, run_d;
  logic [LIM_W-1:0] idle_q, idle_d;

  always_comb begin
    act_d     = act_q;
    lvl_d     = lvl_q;
    run_d     = run_q;
    idle_d    = idle_q;
    push      = 1'b0;
    push_byte = '0;
    end_evt   = 1'b0;
    if (tick) begin
      if (!act_q) begin
        if (level) begin
          act_d  = 1'b1;
          lvl_d  = 1'b1;
          run_d  = 7'd1;
          idle_d = '0;
        end
      end else if (level != lvl_q) begin
        push      = 1'b1;
        push_byte = run_byte(lvl_q, run_q);
        lvl_d     = level;
        run_d     = 7'd1;
        idle_d    = level ? '0 : LIM_W'(1);
      end else begin
        if (!level) idle_d = idle_q + 1'b1;
        if (!level && limit > LIM_W'(1) && idle_d == limit) begin
          push      = 1'b1;
          push_byte = END_MARK;
          end_evt   = 1'b1;
          act_d     = 1'b0;
          run_d     = '0;
          idle_d    = '0;
        end else if (run_q == RUN_MAX) begin
          push      = 1'b1;
          push_byte = run_byte(lvl_q, RUN_MAX);
          run_d     = 7'd1;
        end else begin
          run_d = run_q + 1'b1;
        end
      end
    end
    if (!rx_en) begin
      act_d  = 1'b0;
      lvl_d  = 1'b0;
      run_d  = '0;
      idle_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      lvl_q  <= 1'b0;
      run_q  <= '0;
      idle_q <= '0;
    end else begin
      act_q  <= act_d;
      lvl_q  <= lvl_d;
      run_q  <= run_d;
      idle_q <= idle_d;
    end
  end

  // R1: a run byte never carries a zero length
  assert_len_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !end_evt) |-> (push_byte[6:0] != 7'd0));

  // R4: the packer is idle after an end marker
  assert_end_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> !act_q);
endmodule

// File: rtl/irrl_fifo.sv
module irrl_fifo #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [7:0]    wdata,
  input  logic          pop,
  output logic [7:0]    rdata,
  output logic [CW-1:0] count,
  output logic          ovf,
  output logic          accepted
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] count_q;
  logic          full, empty, do_pop;

  assign full     = (count_q == CW'(DEPTH));
  assign empty    = (count_q == '0);
  assign accepted = push && !full && !clr;
  assign ovf      = push && full && !clr;
  assign do_pop   = pop && !empty && !clr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
    end else if (clr) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
    end else begin
      if (accepted) wr_q <= nxt(wr_q);
      if (do_pop)   rd_q <= nxt(rd_q);
      case ({accepted, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accepted) mem[wr_q] <= wdata;
  end

  assign rdata = mem[rd_q];
  assign count = count_q;

  // R10: a clear leaves the FIFO empty
  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count_q == '0));

  // R9: count never exceeds the depth
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));

  // R9: a dropped push does not change the count
  assert_full_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> $stable(count_q));
endmodule

// File: rtl/irrl_rx_top.sv
module irrl_rx_top
  import irrl_pkg::*;
#(
  parameter int CLK_PER_US = 2,
  parameter int DEPTH      = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ir_in,
  input  logic       dev_en,
  input  logic       rx_en,
  input  logic       rx_invert,
  input  logic [1:0] period_sel,
  input  logic [7:0] limit_hi,
  input  logic [7:0] limit_lo,
  input  logic [7:0] trig_lvl,
  input  logic       fifo_clr,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic [7:0] fifo_cnt,
  input  logic [7:0] status_clr,
  input  logic [7:0] irq_en,
  output logic [7:0] status,
  output logic       irq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          level, tick, push, end_evt, ovf, accepted;
  logic [7:0]    push_byte;
  logic [CW-1:0] count;
  logic [7:0]    cnt8;
  logic [STS_W-1:0] sts_q, set_vec;

  irrl_sampler #(.CLK_PER_US(CLK_PER_US)) u_sampler (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .invert(rx_invert),
    .per_sel(period_sel), .ir_in(ir_in), .level(level), .tick(tick)
  );

  irrl_packer #(.LIM_W(16)) u_packer (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick(tick), .level(level),
    .limit({limit_hi, limit_lo}), .push(push), .push_byte(push_byte),
    .end_evt(end_evt)
  );

  irrl_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push(push), .wdata(push_byte),
    .pop(rd_en), .rdata(rd_data), .count(count), .ovf(ovf), .accepted(accepted)
  );

  assign cnt8 = 8'(count);

  always_comb begin
    set_vec          = '0;
    set_vec[BIT_RDR] = accepted || ovf;
    set_vec[BIT_RTR] = (trig_lvl != 8'd0) && (cnt8 >= trig_lvl);
    set_vec[BIT_PE]  = end_evt;
    set_vec[BIT_RFO] = ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_q & ~status_clr) | set_vec;
  end

  assign status   = sts_q;
  assign irq      = |(sts_q & irq_en);
  assign fifo_cnt = dev_en ? cnt8 : 8'hFF;

  // R9: overrun leaves both overrun and data-ready flags set
  assert_ovf_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (status[BIT_RFO] && status[BIT_RDR]));

  // R4: packet end raises its flag
  assert_pe_on_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> status[BIT_PE]);

  // R7: write-one clear takes effect when no set competes
  assert_w1c_pe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clr[BIT_PE] && !end_evt) |=> !status[BIT_PE]);
endmodule

// File: tb/test_irrl_rx_top.sv
module test_irrl_rx_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, ir_in, dev_en, rx_en, rx_invert, fifo_clr, rd_en;
  logic [1:0] period_sel;
  logic [7:0] limit_hi, limit_lo, trig_lvl, rd_data, fifo_cnt;
  logic [7:0] status_clr, irq_en, status;
  logic       irq;
  logic       mon_on = 1'b0, mon_pop = 1'b0, tb_pop = 1'b0;
  int         n_checks = 0, n_errors = 0, per_cyc = 2;
  bit         inv = 1'b0, done = 1'b0;
  logic [7:0] exp_q[$];

  assign rd_en = mon_pop | tb_pop;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irrl_rx_top i_irrl_rx_top (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .dev_en(dev_en), .rx_en(rx_en),
    .rx_invert(rx_invert), .period_sel(period_sel), .limit_hi(limit_hi),
    .limit_lo(limit_lo), .trig_lvl(trig_lvl), .fifo_clr(fifo_clr), .rd_en(rd_en),
    .rd_data(rd_data), .fifo_cnt(fifo_cnt), .status_clr(status_clr),
    .irq_en(irq_en), .status(status), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops bytes and compares them with the scoreboard queue
  always @(negedge clk) begin
    mon_pop = 1'b0;
    if (mon_on && rst_n && fifo_cnt != 8'h00 && fifo_cnt != 8'hFF) begin
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected byte", rd_data, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R1/R2 stream byte", rd_data, e);
      end
      mon_pop = 1'b1;
    end
  end

  task automatic drive(input bit lvl, input int k);
    ir_in = lvl ^ inv;
    repeat (k * per_cyc) @(negedge clk);
  endtask

  task automatic exp_run(input bit lvl, input int k);
    int m;
    m = (k - 1) / 127;
    for (int i = 0; i < m; i++) exp_q.push_back({lvl, 7'h7F});
    exp_q.push_back({lvl, 7'(k - 127 * m)});
  endtask

  task automatic pr(input bit lvl, input int k);
    exp_run(lvl, k);
    drive(lvl, k);
  endtask

  task automatic pkt_end(input int lim);
    int m;
    m = (lim - 2) / 127;
    for (int i = 0; i < m; i++) exp_q.push_back(8'h7F);
    exp_q.push_back(8'h80);
    drive(1'b0, lim + 3);
  endtask

  task automatic set_limit(input int lim);
    limit_hi = 8'(lim >> 8);
    limit_lo = 8'(lim);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 5000 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    chk(fifo_cnt == 8'h00, tag, fifo_cnt, 0);
  endtask

  task automatic clear_status();
    status_clr = 8'hFF;
    @(negedge clk);
    status_clr = 8'h00;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ir_in = 1'b0; dev_en = 1'b0; rx_en = 1'b0; rx_invert = 1'b0;
    fifo_clr = 1'b0; period_sel = 2'b01; trig_lvl = 8'd0; status_clr = 8'h00;
    irq_en = 8'h00; set_limit(10);
    repeat (3) @(negedge clk);
    chk(fifo_cnt == 8'hFF, "R11 disabled count", fifo_cnt, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 8'h00, "R7 reset status", status, 0);
    chk(irq == 1'b0, "R12 reset irq", irq, 0);
    dev_en = 1'b1;
    #1;
    chk(fifo_cnt == 8'h00, "R11 enabled count", fifo_cnt, 0);

    // R1/R4 basic packet at 1 us period
    rx_en = 1'b1; mon_on = 1'b1;
    drive(1'b0, 5);
    pr(1'b1, 3); pr(1'b0, 5); pr(1'b1, 2); pkt_end(10);
    drain("R1 basic packet drained");
    chk(status[5] == 1'b1, "R4 packet end flag", status[5], 1);

    // R2 saturation on pulses and spaces
    set_limit(200);
    pr(1'b1, 300); pr(1'b0, 130); pr(1'b1, 127); pr(1'b0, 3); pr(1'b1, 128);
    pkt_end(200);
    drain("R2 long runs drained");

    // R6 inversion
    set_limit(10);
    rx_en = 1'b0; inv = 1'b1; rx_invert = 1'b1; ir_in = 1'b1;
    @(negedge clk); rx_en = 1'b1;
    pr(1'b1, 4); pr(1'b0, 2); pr(1'b1, 1); pkt_end(10);
    drain("R6 inverted packet drained");
    rx_en = 1'b0; inv = 1'b0; rx_invert = 1'b0; ir_in = 1'b0;
    @(negedge clk); rx_en = 1'b1;

    // R5 other sample periods
    period_sel = 2'b10; per_cyc = 50;
    pr(1'b1, 3); pr(1'b0, 2); pr(1'b1, 5); pkt_end(4);
    drain("R5 25us period drained");
    period_sel = 2'b00; per_cyc = 100;
    pr(1'b1, 2); pr(1'b0, 1); pr(1'b1, 1); pkt_end(3);
    drain("R5 50us period drained");
    period_sel = 2'b11; per_cyc = 200;
    pr(1'b1, 1); pkt_end(2);
    drain("R5 100us period drained");
    period_sel = 2'b01; per_cyc = 2;

    // R7/R12 flag positions, write-one clear and interrupt masking
    chk(status == 8'hA0, "R7 flag positions", status, 8'hA0);
    irq_en = 8'h20; #1;
    chk(irq == 1'b1, "R12 irq on packet end", irq, 1);
    status_clr = 8'h2F; @(negedge clk); status_clr = 8'h00;
    chk(status == 8'h80, "R7 clear of packet end only", status, 8'h80);
    chk(irq == 1'b0, "R12 irq masked", irq, 0);
    irq_en = 8'h80; #1;
    chk(irq == 1'b1, "R12 irq on data ready", irq, 1);
    irq_en = 8'h00;
    clear_status();

    // R8 trigger level and R10 clear (monitor off)
    mon_on = 1'b0; trig_lvl = 8'd3;
    drive(1'b1, 1); drive(1'b0, 1); drive(1'b1, 1);
    repeat (6) @(negedge clk);
    chk(fifo_cnt == 8'd2, "R8 two bytes stored", fifo_cnt, 2);
    chk(status[6] == 1'b0, "R8 below trigger", status[6], 0);
    drive(1'b0, 1);
    repeat (6) @(negedge clk);
    chk(fifo_cnt == 8'd3, "R8 three bytes stored", fifo_cnt, 3);
    chk(status[6] == 1'b1, "R8 trigger reached", status[6], 1);
    chk(status[7] == 1'b1, "R8 data ready", status[7], 1);
    drive(1'b0, 14);
    fifo_clr = 1'b1; @(negedge clk); fifo_clr = 1'b0;
    chk(fifo_cnt == 8'd0, "R10 clear empties", fifo_cnt, 0);
    trig_lvl = 8'd0;
    clear_status();

    // R13 pop on empty ignored
    tb_pop = 1'b1; @(negedge clk); tb_pop = 1'b0; @(negedge clk);
    chk(fifo_cnt == 8'd0, "R13 pop on empty", fifo_cnt, 0);

    // R9 overrun: 20 bytes into 16 entries
    for (int i = 0; i < 10; i++) begin
      drive(1'b1, 1); drive(1'b0, 1);
    end
    drive(1'b0, 12);
    chk(fifo_cnt == 8'd16, "R9 FIFO full", fifo_cnt, 16);
    chk(status[4] == 1'b1, "R9 overrun flag", status[4], 1);
    chk(status[7] == 1'b1, "R9 data ready with overrun", status[7], 1);
    for (int i = 0; i < 8; i++) begin
      exp_q.push_back(8'h81); exp_q.push_back(8'h01);
    end
    mon_on = 1'b1;
    drain("R9 oldest bytes kept in order");
    clear_status();

    // R3 disabling drops the open run; spaces while idle are ignored
    mon_on = 1'b0;
    drive(1'b1, 5);
    rx_en = 1'b0; ir_in = 1'b0;
    repeat (10) @(negedge clk);
    rx_en = 1'b1;
    drive(1'b0, 20);
    chk(fifo_cnt == 8'd0, "R3 dropped run and ignored spaces", fifo_cnt, 0);

    // R4 limit 0 disables packet end
    set_limit(0);
    drive(1'b1, 2); drive(1'b0, 40);
    chk(fifo_cnt == 8'd1, "R4 no end marker when disabled", fifo_cnt, 1);
    chk(rd_data == 8'h82, "R4 pulse byte only", rd_data, 8'h82);
    chk(status[5] == 1'b0, "R4 no packet end flag", status[5], 0);
    rx_en = 1'b0; fifo_clr = 1'b1; @(negedge clk); fifo_clr = 1'b0;

    dev_en = 1'b0; #1;
    chk(fifo_cnt == 8'hFF, "R11 disabled again", fifo_cnt, 8'hFF);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule